// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block is the write-only configuration port of a transmitter controller. An external host drives three pins: a serial clock, a serial data line and a load strobe. Each 24-bit control word goes in most significant bit first. The block samples the data line into a shift register on every rising edge of the serial clock. A rising edge on the strobe copies the shifted word into one of four control registers. The top two bits of the word choose the register. The strobe need not be synchronous to the serial clock. The host keeps the serial clock and data low while the strobe is high.

All three pins pass through two-flop synchronizers into the system clock domain. Edge detection and all register updates happen in that domain. The block decodes the four stored registers into named fields for the rest of the chip:
- two 22-bit synthesizer frequency words, one for each operating mode
- an 8-bit FSK deviation
- a power-amplifier code and VCO and PLL enables for each mode
- a divider ratio select
- a 3-bit acquisition-acceleration code
- a modulation-mode bit

The registers stay writable at any time, including standby, because no input of the block gates them. Each register keeps its value until it is written again or the block is reset.

Top module: `ser_cfg_bank`

## Requirements
- R1: While `rst` is high, and on the first system clock after it rises, every decoded output field is zero.
- R2: Each synchronized rising edge of `ser_clk` shifts the synchronized `ser_data` level into bit 0 of a 24-bit shift register, so the first bit sent ends up in bit 23 (most significant bit first).
- R3: A synchronized rising edge of `ser_strobe` writes exactly one register, chosen by word bits [23:22]: 00 = register A, 01 = register B, 10 = register C, 11 = register D. Registers not chosen keep their contents.
- R4: Register A bits [21:0] drive `freq_m0`. Register B bits [21:0] drive `freq_m1`.
- R5: Register C gives the following fields:
  - bits [20:18] drive `acq_accel`
  - bit 17 drives `div_sel_512` (0 = divide by 256, 1 = divide by 512)
  - bit 16 drives `mod_off` (0 = FSK/FM modulation enabled)
  - bits [10:9] drive `pa_m0`
  - bit 11 drives `vco_en_m0`
  - bit 12 drives `pll_en_m0`
- R6: Register D gives the following fields:
  - bits [20:13] drive `fsk_dev`
  - bits [10:9] drive `pa_m1`
  - bit 11 drives `vco_en_m1`
  - bit 12 drives `pll_en_m1`
- R7: The power-amplifier fields carry the code as written: 00 = off, 01 = 10 dB attenuation, 10 = 20 dB attenuation, 11 = 0 dB attenuation.
- R8: Rising edges of `ser_clk` seen while the synchronized strobe is high do not shift. A later strobe pulse with no clock edges in between therefore writes the same word again.
- R9: A strobe rising edge driven at the pin shows on the outputs within 4 system clock cycles. The outputs do not change in any cycle that does not follow a strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock from the host, asynchronous |
| ser_data | input | 1 | Serial data, sampled on the serial clock rising edge |
| ser_strobe | input | 1 | Load strobe, asynchronous, rising edge writes a register |
| freq_m0 | output | 22 | Mode-0 frequency word |
| freq_m1 | output | 22 | Mode-1 frequency word |
| fsk_dev | output | 8 | FSK deviation |
| acq_accel | output | 3 | Acquisition-acceleration code |
| div_sel_512 | output | 1 | Divider select, 1 = 512 |
| mod_off | output | 1 | 1 disables FSK/FM modulation |
| pa_m0 | output | 2 | Mode-0 power-amplifier code |
| vco_en_m0 | output | 1 | Mode-0 VCO enable |
| pll_en_m0 | output | 1 | Mode-0 PLL enable |
| pa_m1 | output | 2 | Mode-1 power-amplifier code |
| vco_en_m1 | output | 1 | Mode-1 VCO enable |
| pll_en_m1 | output | 1 | Mode-1 PLL enable |

## Verification
A corrupt shift register cannot be seen until the next strobe. The fault then shows at once as a wrong field, or as the wrong register changing. The bench therefore checks every field of all four registers after each word, not only the register it just wrote. An edge detector that misses a clock edge, or sees one twice, moves every later bit by one place. A sweep of many bit patterns into each register exposes that in the first word after the fault. A write that lands late or in the wrong register shows up in the check taken four system cycles after the strobe rises.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int NUM_REGS = 1 << ADDR_W;
    localparam int FREQ_W   = 22;
    localparam int DEV_W    = 8;
    localparam int DEV_LSB  = 13;
    localparam int ACC_W    = 3;
    localparam int ACC_LSB  = 18;
    localparam int DIV_BIT  = 17;
    localparam int MOD_BIT  = 16;
    localparam int PA_LSB   = 9;
    localparam int VCO_BIT  = 11;
    localparam int PLL_BIT  = 12;

    typedef enum logic [1:0] {
        PA_OFF   = 2'b00,
        PA_ATT10 = 2'b01,
        PA_ATT20 = 2'b10,
        PA_FULL  = 2'b11
    } pa_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_A = 2'b00,
        SEL_B = 2'b01,
        SEL_C = 2'b10,
        SEL_D = 2'b11
    } reg_sel_e;

    typedef struct packed {
        pa_mode_e pa;
        logic     vco_en;
        logic     pll_en;
    } mode_ctl_t;

    typedef struct packed {
        logic [FREQ_W-1:0] freq0;
        logic [FREQ_W-1:0] freq1;
        logic [DEV_W-1:0]  dev;
        logic [ACC_W-1:0]  accel;
        logic              div512;
        logic              mod_off;
        mode_ctl_t         m0;
        mode_ctl_t         m1;
    } cfg_t;

    function automatic mode_ctl_t unpack_mode(input logic [PAY_W-1:0] p);
        mode_ctl_t m;
        m.pa     = pa_mode_e'(p[PA_LSB +: 2]);
        m.vco_en = p[VCO_BIT];
        m.pll_en = p[PLL_BIT];
        return m;
    endfunction

    function automatic reg_sel_e word_sel(input logic [WORD_W-1:0] w);
        return reg_sel_e'(w[WORD_W-1 -: ADDR_W]);
    endfunction
endpackage

// File: rtl/cfgbank_sync.sv
module cfgbank_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d[gi]};
            end
            assign q[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/cfgbank_edge.sv
module cfgbank_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/cfgbank_shift.sv
module cfgbank_shift #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], din};
    end
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
    import cfgbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [WORD_W-1:0]   word,
    output logic [NUM_REGS-1:0] wr_en,
    output cfg_t                cfg
);
    logic [PAY_W-1:0] payload [NUM_REGS];
    reg_sel_e         sel;

    assign sel = word_sel(word);

    always_comb begin
        wr_en = '0;
        if (load) wr_en[sel] = 1'b1;
    end

    genvar gr;
    generate
        for (gr = 0; gr < NUM_REGS; gr++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)            payload[gr] <= '0;
                else if (wr_en[gr]) payload[gr] <= word[PAY_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        cfg         = '0;
        cfg.freq0   = payload[SEL_A][FREQ_W-1:0];
        cfg.freq1   = payload[SEL_B][FREQ_W-1:0];
        cfg.accel   = payload[SEL_C][ACC_LSB +: ACC_W];
        cfg.div512  = payload[SEL_C][DIV_BIT];
        cfg.mod_off = payload[SEL_C][MOD_BIT];
        cfg.m0      = unpack_mode(payload[SEL_C]);
        cfg.dev     = payload[SEL_D][DEV_LSB +: DEV_W];
        cfg.m1      = unpack_mode(payload[SEL_D]);
    end

    logic unused_bits;
    assign unused_bits = ^{payload[SEL_C][21], payload[SEL_C][15:13], payload[SEL_C][8:0],
                           payload[SEL_D][21], payload[SEL_D][8:0]};
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_strobe,
    output logic [FREQ_W-1:0] freq_m0,
    output logic [FREQ_W-1:0] freq_m1,
    output logic [DEV_W-1:0]  fsk_dev,
    output logic [ACC_W-1:0]  acq_accel,
    output logic              div_sel_512,
    output logic              mod_off,
    output logic [1:0]        pa_m0,
    output logic              vco_en_m0,
    output logic              pll_en_m0,
    output logic [1:0]        pa_m1,
    output logic              vco_en_m1,
    output logic              pll_en_m1
);
    localparam int PIN_N = 3;
    localparam int P_CLK = 0;
    localparam int P_DAT = 1;
    localparam int P_STB = 2;

    logic [PIN_N-1:0]    pins_s;
    logic [1:0]          rises;
    logic                clk_rise, stb_rise, stb_lvl, data_s, shift_en;
    logic [WORD_W-1:0]   shreg;
    logic [NUM_REGS-1:0] wr_en;
    cfg_t                cfg;

    cfgbank_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .d({ser_strobe, ser_data, ser_clk}),
        .q(pins_s)
    );

    assign data_s  = pins_s[P_DAT];
    assign stb_lvl = pins_s[P_STB];

    cfgbank_edge #(.WIDTH(2)) u_edge (
        .clk(clk), .rst(rst),
        .lvl({pins_s[P_STB], pins_s[P_CLK]}),
        .rise(rises)
    );

    assign clk_rise = rises[0];
    assign stb_rise = rises[1];
    assign shift_en = clk_rise & ~stb_lvl;

    cfgbank_shift #(.WIDTH(WORD_W)) u_shift (
        .clk(clk), .rst(rst),
        .shift_en(shift_en),
        .din(data_s),
        .q(shreg)
    );

    cfgbank_regs u_regs (
        .clk(clk), .rst(rst),
        .load(stb_rise),
        .word(shreg),
        .wr_en(wr_en),
        .cfg(cfg)
    );

    assign freq_m0     = cfg.freq0;
    assign freq_m1     = cfg.freq1;
    assign fsk_dev     = cfg.dev;
    assign acq_accel   = cfg.accel;
    assign div_sel_512 = cfg.div512;
    assign mod_off     = cfg.mod_off;
    assign pa_m0       = cfg.m0.pa;
    assign vco_en_m0   = cfg.m0.vco_en;
    assign pll_en_m0   = cfg.m0.pll_en;
    assign pa_m1       = cfg.m1.pa;
    assign vco_en_m1   = cfg.m1.vco_en;
    assign pll_en_m1   = cfg.m1.pll_en;
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                clk_rise,
    input logic                stb_rise,
    input logic                stb_lvl,
    input logic                data_s,
    input logic [WORD_W-1:0]   shreg,
    input logic [NUM_REGS-1:0] wr_en,
    input cfg_t                cfg
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> cfg == '0); // R1
    AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (rst)
        (clk_rise && !stb_lvl) |=> shreg == {$past(shreg[WORD_W-2:0]), $past(data_s)}); // R2
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        stb_rise |-> $countones(wr_en) == 1); // R3
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !stb_rise |-> wr_en == '0); // R3
    AST_FREQ0_LOAD: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && shreg[23:22] == 2'b00) |=> cfg.freq0 == $past(shreg[21:0])); // R4
    AST_ACCEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && shreg[23:22] == 2'b10) |=> cfg.accel == $past(shreg[20:18])); // R5
    AST_DEV_LOAD: assert property (@(posedge clk) disable iff (rst)
        (stb_rise && shreg[23:22] == 2'b11) |=> cfg.dev == $past(shreg[20:13])); // R6
    AST_HOLD_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        stb_lvl |=> $stable(shreg)); // R8
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
        !stb_rise |=> $stable(cfg)); // R9
endmodule

bind ser_cfg_bank cfgbank_chk u_chk (
    .clk(clk), .rst(rst), .clk_rise(clk_rise), .stb_rise(stb_rise),
    .stb_lvl(stb_lvl), .data_s(data_s), .shreg(shreg), .wr_en(wr_en), .cfg(cfg)
);

// File: tb/ser_cfg_bank_tb.sv
module ser_cfg_bank_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic [21:0] freq_m0, freq_m1;
    logic [7:0]  fsk_dev;
    logic [2:0]  acq_accel;
    logic        div_sel_512, mod_off, vco_en_m0, pll_en_m0, vco_en_m1, pll_en_m1;
    logic [1:0]  pa_m0, pa_m1;

    int n_chk = 0;
    int n_fail = 0;
    logic [21:0] pay [4];

    always #10 clk = ~clk;

    ser_cfg_bank u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe),
        .freq_m0(freq_m0), .freq_m1(freq_m1), .fsk_dev(fsk_dev), .acq_accel(acq_accel),
        .div_sel_512(div_sel_512), .mod_off(mod_off),
        .pa_m0(pa_m0), .vco_en_m0(vco_en_m0), .pll_en_m0(pll_en_m0),
        .pa_m1(pa_m1), .vco_en_m1(vco_en_m1), .pll_en_m1(pll_en_m1)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R4 R5 R6 R7: expected fields from the model payloads
    task automatic check_all(input string req);
        chk(req, "freq_m0", int'(freq_m0), int'(pay[0]));
        chk(req, "freq_m1", int'(freq_m1), int'(pay[1]));
        chk(req, "acq_accel", int'(acq_accel), int'((pay[2] >> 18) & 22'h7));
        chk(req, "div_sel_512", int'(div_sel_512), int'(pay[2][17]));
        chk(req, "mod_off", int'(mod_off), int'(pay[2][16]));
        chk(req, "pa_m0", int'(pa_m0), int'((pay[2] >> 9) & 22'h3));
        chk(req, "vco_en_m0", int'(vco_en_m0), int'(pay[2][11]));
        chk(req, "pll_en_m0", int'(pll_en_m0), int'(pay[2][12]));
        chk(req, "fsk_dev", int'(fsk_dev), int'((pay[3] >> 13) & 22'hFF));
        chk(req, "pa_m1", int'(pa_m1), int'((pay[3] >> 9) & 22'h3));
        chk(req, "vco_en_m1", int'(vco_en_m1), int'(pay[3][11]));
        chk(req, "pll_en_m1", int'(pll_en_m1), int'(pay[3][12]));
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int b = 23; b >= 0; b--) begin
            ser_data = w[b];
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
            ser_clk = 1'b0;
        end
        ser_data = 1'b0;
        wait_n(3);
    endtask

    task automatic strobe_pulse();
        ser_strobe = 1'b1;
        wait_n(4);
    endtask

    task automatic send_word(input logic [23:0] w, input string req);
        shift_word(w);
        strobe_pulse();
        pay[w[23:22]] = w[21:0];
        check_all(req);
        ser_strobe = 1'b0;
        wait_n(4);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 4; i++) pay[i] = '0;
        wait_n(5);
        check_all("R1");
        rst = 1'b0;
        wait_n(3);

        // R2: single bits at both ends show MSB-first order
        send_word({2'b00, 22'h200001}, "R2");
        send_word({2'b01, 22'h000003}, "R2");

        // R3 R4 R5 R6 R7: sweep every register with varied payloads
        for (int k = 0; k < 32; k++) begin
            for (int a = 0; a < 4; a++) begin
                logic [21:0] p;
                p = 22'(k * 32'h1B3D5 + a * 32'h3A17 + 32'h2C1A7);
                p[12:9]  = 4'(k + a);
                p[20:16] = 5'(k) ^ 5'h15;
                send_word({2'(a), p}, "R3");
            end
        end

        // R8: clock edges while strobe is high must not shift
        shift_word({2'b00, 22'h0ABCDE});
        ser_strobe = 1'b1;
        wait_n(4);
        pay[0] = 22'h0ABCDE;
        check_all("R8");
        ser_data = 1'b1;
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b1; wait_n(3);
            ser_clk = 1'b0; wait_n(3);
        end
        ser_data = 1'b0;
        ser_strobe = 1'b0;
        wait_n(4);
        ser_strobe = 1'b1;
        wait_n(4);
        check_all("R8");
        ser_strobe = 1'b0;
        wait_n(4);

        // R9: pin-to-output latency of a strobe is at most 4 cycles
        shift_word({2'b11, 22'h1FE000});
        ser_strobe = 1'b1;
        wait_n(4);
        chk("R9", "fsk_dev latency", int'(fsk_dev), 8'hFF);
        pay[3] = 22'h1FE000;
        ser_strobe = 1'b0;
        wait_n(10);
        check_all("R9");

        // R1: reset clears after activity
        @(negedge clk) rst = 1'b1;
        wait_n(2);
        for (int i = 0; i < 4; i++) pay[i] = '0;
        check_all("R1");
        rst = 1'b0;
        wait_n(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule